// File: doc/BRIEF.md
# Link Scramble Word Generator

This block produces the pseudo-random word stream that a serial storage link XORs onto its payload to spread the spectrum. It keeps a 16-bit linear feedback shift register context. In one clock it advances that context by 32 serial shifts, using a parallel XOR network, and presents the 32 serial output bits of those shifts as one scramble word.

A link controller holds the enable high on every cycle that consumes a payload word. It drops the enable on cycles that carry no scrambled data, and the stream then pauses without losing its place. A synchronous reset restarts the stream from its fixed seed. The XOR with data, and any decision on which words get scrambled, belong to the caller.

Top module: `scrambler_gen`

## Requirements
- R1: The context is 16 bits wide. A rising clock edge with `rst` high loads it with 0xF0F6.
- R2: One serial shift is defined as follows. The output bit is context bit 15. The new context is the old context shifted left by one, with a zero entering bit 0, XORed with 0xA011 when the old bit 15 was 1. Mask 0xA011 sets bits 15, 13, 4 and 0, which gives polynomial x^16+x^15+x^13+x^4+1.
- R3: Bit i of `scr_word` is the output bit of serial shift i, taken from the current context, with bit 0 the earliest. The word depends only on the context registered in the current cycle.
- R4: A rising edge with `en` high and `rst` low replaces the context with the state reached after 32 serial shifts. A new word is therefore presented after each such edge.
- R5: A rising edge with `en` low and `rst` low leaves the context and `scr_word` unchanged.
- R6: `rst` takes priority over `en`. With both high, the context is loaded with the seed and is not advanced.
- R7: The context is never all-zero, so `scr_word` is never zero.
- R8: After 65535 enabled steps from the seed, the word stream repeats the word of the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset to the seed |
| en | input | 1 | Advance the generator by one word |
| scr_word | output | 32 | Current scramble word, bit 0 earliest |

## Verification
The assertions check four things on every cycle. The context and the word hold while the enable is low. An enabled step loads exactly the state that the parallel network offered. The context never falls into the all-zero lock-up state.

Only the bench's scenarios can show that the word values themselves are right. It compares more than 65535 consecutive words against a bit-serial software model, and it checks the return to the seed word after one full period. It also checks the seed value after reset, and that reset wins when the enable is also high.

// File: rtl/scr_pkg.sv
package scr_pkg;
    localparam int unsigned SCR_STATE_W = 16;
    localparam int unsigned SCR_WORD_W  = 32;
    localparam logic [SCR_STATE_W-1:0] SCR_POLY_MASK = 16'hA011;
    localparam logic [SCR_STATE_W-1:0] SCR_SEED      = 16'hF0F6;

    typedef logic [SCR_STATE_W-1:0] scr_ctx_t;
    typedef logic [SCR_WORD_W-1:0]  scr_word_t;

    typedef struct packed {
        scr_word_t word;
        scr_ctx_t  nxt;
    } scr_step_t;
endpackage

// File: rtl/scr_stride_net.sv
module scr_stride_net #(
    parameter int unsigned STATE_W = 16,
    parameter int unsigned WORD_W  = 32,
    parameter logic [STATE_W-1:0] POLY_MASK = 16'hA011
) (
    input  logic [STATE_W-1:0] ctx,
    output logic [WORD_W-1:0]  word,
    output logic [STATE_W-1:0] nxt
);
    localparam int unsigned MSB = STATE_W - 1;

    logic [STATE_W-1:0] stage [0:WORD_W];

    assign stage[0] = ctx;

    for (genvar g = 0; g < WORD_W; g++) begin : g_shift
        assign word[g]      = stage[g][MSB];
        assign stage[g + 1] = {stage[g][MSB-1:0], 1'b0}
                            ^ (stage[g][MSB] ? POLY_MASK : '0);
    end

    assign nxt = stage[WORD_W];
endmodule

// File: rtl/scr_ctx_reg.sv
module scr_ctx_reg #(
    parameter int unsigned STATE_W = 16,
    parameter logic [STATE_W-1:0] SEED = 16'hF0F6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [STATE_W-1:0] nxt,
    output logic [STATE_W-1:0] ctx_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= SEED;
        end else if (en) begin
            ctx_q <= nxt;
        end
    end

    // R4: an enabled step takes the state offered by the network
    p_step_loads_next_r4: assert property (@(posedge clk) disable iff (rst)
        en |=> ctx_q == $past(nxt));

    // R5: the context holds while disabled
    p_ctx_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(ctx_q));

    // R7: no lock-up state
    p_ctx_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        ctx_q != '0);
endmodule

// File: rtl/scrambler_gen.sv
module scrambler_gen
    import scr_pkg::*;
#(
    parameter int unsigned STATE_W = SCR_STATE_W,
    parameter int unsigned WORD_W  = SCR_WORD_W,
    parameter logic [STATE_W-1:0] POLY_MASK = SCR_POLY_MASK,
    parameter logic [STATE_W-1:0] SEED      = SCR_SEED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    output logic [WORD_W-1:0] scr_word
);
    logic [STATE_W-1:0] ctx_q;
    logic [STATE_W-1:0] ctx_nxt;
    logic [WORD_W-1:0]  word_c;

    scr_stride_net #(
        .STATE_W  (STATE_W),
        .WORD_W   (WORD_W),
        .POLY_MASK(POLY_MASK)
    ) net_i (
        .ctx (ctx_q),
        .word(word_c),
        .nxt (ctx_nxt)
    );

    scr_ctx_reg #(
        .STATE_W(STATE_W),
        .SEED   (SEED)
    ) ctx_i (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .nxt  (ctx_nxt),
        .ctx_q(ctx_q)
    );

    assign scr_word = word_c;

    // R5: the presented word freezes while disabled
    p_word_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(scr_word));
endmodule

// File: tb/scrambler_gen_tb_top.sv
module scrambler_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b1;
    logic [31:0] scr_word;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] m;

    always #4 clk = ~clk;

    scrambler_gen dut_i (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .scr_word(scr_word)
    );

    // bit-serial reference model
    function automatic logic [15:0] mdl_shift(input logic [15:0] s);
        logic [15:0] t;
        t = s << 1;
        if (s[15]) t = t ^ 16'hA011;
        return t;
    endfunction

    function automatic logic [31:0] mdl_word(input logic [15:0] s);
        logic [31:0] w;
        logic [15:0] t;
        t = s;
        for (int i = 0; i < 32; i++) begin
            w[i] = t[15];
            t = mdl_shift(t);
        end
        return w;
    endfunction

    function automatic logic [15:0] mdl_adv(input logic [15:0] s);
        logic [15:0] t;
        t = s;
        for (int i = 0; i < 32; i++) t = mdl_shift(t);
        return t;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // stimulus table: {rst, en}
    localparam logic [1:0] STIM [0:15] = '{
        2'b01, 2'b00, 2'b00, 2'b01, 2'b11, 2'b01, 2'b01, 2'b00,
        2'b10, 2'b01, 2'b00, 2'b01, 2'b11, 2'b11, 2'b01, 2'b01
    };

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] first_w;
        logic [31:0] held;
        // reset with enable high: R1, R6
        repeat (2) @(posedge clk);
        @(negedge clk);
        m = 16'hF0F6;
        first_w = mdl_word(m);
        chk("R1 R6 seed word under reset", scr_word, first_w);
        rst = 1'b0;

        // full period run against serial model: R2 R3 R4 R7
        for (int k = 0; k < 65535; k++) begin
            chk("R2 R3 R4 word vs serial model", scr_word, mdl_word(m));
            if (scr_word == 32'h0) chk("R7 word nonzero", scr_word, 32'hFFFF_FFFF);
            @(posedge clk);
            m = mdl_adv(m);
            @(negedge clk);
        end
        chk("R8 period returns to seed word", scr_word, first_w);
        chk("R8 model back at seed", {16'h0, m}, 32'h0000_F0F6);

        // table walk
        for (int e = 0; e < 16; e++) begin
            rst = STIM[e][1];
            en  = STIM[e][0];
            @(posedge clk);
            if (STIM[e][1]) m = 16'hF0F6;
            else if (STIM[e][0]) m = mdl_adv(m);
            @(negedge clk);
            if (STIM[e] == 2'b11)      chk("R6 reset wins over enable", scr_word, mdl_word(m));
            else if (STIM[e] == 2'b00) chk("R5 hold while disabled", scr_word, mdl_word(m));
            else if (STIM[e] == 2'b10) chk("R1 reset with enable low", scr_word, mdl_word(m));
            else                       chk("R4 enabled step", scr_word, mdl_word(m));
        end
        rst = 1'b0;

        // long pause: R5
        en = 1'b1;
        repeat (3) @(posedge clk);
        m = mdl_adv(mdl_adv(mdl_adv(m)));
        @(negedge clk);
        held = scr_word;
        en = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R5 word frozen over pause", scr_word, held);
        en = 1'b1;
        @(posedge clk);
        m = mdl_adv(m);
        @(negedge clk);
        chk("R4 resume after pause", scr_word, mdl_word(m));

        // mid-stream reset: R1
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid-stream reset reloads seed", scr_word, first_w);
        @(posedge clk);
        @(negedge clk);
        chk("R4 first step after reset", scr_word, mdl_word(mdl_adv(16'hF0F6)));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule